// File: doc/BRIEF.md
# Presettable Synchronous Binary Up-Counter

This block is a small binary up-counter with a default width of four bits. All state bits change together on the rising clock edge. On any edge the counter does one of four things: it clears, it loads a parallel word, it increments by one, or it holds its value. Two active-high enables control counting, a parallel enable and a trickle enable. Only the trickle enable is passed through to the terminal-count flag. This lets a chain of counters ripple the carry through the trickle path while the parallel enables of all stages are driven together.

A build-time parameter selects the clear style:

- **Asynchronous clear:** the active-low clear empties the register at once, without a clock edge.
- **Synchronous clear:** the clear is sampled like any other control input and wins at the next rising edge.

The synchronous style allows a shortened count. Decode a chosen state and feed it back into the clear input, and the counter restarts from zero after that state.

Top module: `psync_counter`

## Requirements
- R1: With clear and load inactive (both high) and both count enables high, the count rises by exactly one at each rising clock edge.
- R2: With `load_n` low and clear inactive, the count takes the value of `din` at the next rising edge, whatever the levels of `en_par` and `en_trk`.
- R3: With `ASYNC_CLEAR`=1, a low on `clr_n` forces the count to 0 immediately, with no clock edge, and regardless of `load_n` and the enables.
- R4: With `ASYNC_CLEAR`=0, a low on `clr_n` has no effect until the next rising edge. At that edge the count becomes 0, taking priority over a simultaneous load and over counting.
- R5: With clear and load inactive, if either `en_par` or `en_trk` is low, the count keeps its present value across the edge.
- R6: `tc` is high exactly when every count bit is 1 and `en_trk` is high. It follows `en_trk` combinationally, within the same cycle, and `en_par` has no effect on it.
- R7: Counting from the all-ones value (15 at the default width) wraps the count to 0, and `tc` then goes low.
- R8: In the synchronous-clear variant, feeding `clr_n` with the inverse of a decode of count 6 gives the repeating sequence 0,1,2,3,4,5,6,0.
- R9: The count is 0 after the clear has been applied, and the mode priority is clear, then load, then count, then hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous by parameter |
| load_n | input | 1 | Active-low parallel load |
| en_par | input | 1 | Active-high parallel count enable |
| en_trk | input | 1 | Active-high trickle count enable; also gates `tc` |
| din | input | WIDTH | Parallel load word |
| count | output | WIDTH | Present counter value |
| tc | output | 1 | Terminal-count flag |

## Verification
The assertions take for granted that all control inputs and `din` are stable around the rising edge and never X after time zero. In the asynchronous variant they also assume that `clr_n` is not released at the same moment as an edge. The stimulus changes every input two time units after an edge, well clear of the next one. The bench drives the clear low from time zero and releases it mid-cycle. The only input derived from the outputs is the modulo-7 feedback into the synchronous clear, and it also settles mid-cycle.

// File: rtl/bcnt_pkg.sv
package bcnt_pkg;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_COUNT = 2'd2,
        MODE_HOLD  = 2'd3
    } bcnt_mode_e;

    typedef struct packed {
        logic clear;
        logic load;
        logic par_en;
        logic trk_en;
    } bcnt_ctrl_t;

    function automatic bcnt_ctrl_t bcnt_pack_ctrl(input logic clr_n,
                                                  input logic load_n,
                                                  input logic en_par,
                                                  input logic en_trk);
        bcnt_ctrl_t c;
        c.clear  = ~clr_n;
        c.load   = ~load_n;
        c.par_en = en_par;
        c.trk_en = en_trk;
        return c;
    endfunction

endpackage

// File: rtl/bcnt_mode_sel.sv
module bcnt_mode_sel
    import bcnt_pkg::*;
(
    input  bcnt_ctrl_t ctrl,
    output bcnt_mode_e mode
);
    always_comb begin
        if (ctrl.clear)
            mode = MODE_CLEAR;
        else if (ctrl.load)
            mode = MODE_LOAD;
        else if (ctrl.par_en && ctrl.trk_en)
            mode = MODE_COUNT;
        else
            mode = MODE_HOLD;
    end
endmodule

// File: rtl/bcnt_next.sv
module bcnt_next
    import bcnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  bcnt_mode_e       mode,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (mode)
            MODE_CLEAR: nxt = '0;
            MODE_LOAD:  nxt = din;
            MODE_COUNT: nxt = cur + ONE;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/bcnt_term.sv
module bcnt_term #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             trk_en,
    output logic             tc
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    always_comb tc = trk_en && (cur == ALL_ONES);
endmodule

// File: rtl/psync_counter.sv
module psync_counter
    import bcnt_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             en_par,
    input  logic             en_trk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             tc
);
    localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    bcnt_ctrl_t       ctrl;
    bcnt_mode_e       mode;
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;

    assign ctrl = bcnt_pack_ctrl(clr_n, load_n, en_par, en_trk);

    bcnt_mode_sel u_mode (
        .ctrl (ctrl),
        .mode (mode)
    );

    bcnt_next #(.WIDTH(WIDTH)) u_next (
        .mode (mode),
        .cur  (cnt_q),
        .din  (din),
        .nxt  (cnt_d)
    );

    bcnt_term #(.WIDTH(WIDTH)) u_term (
        .cur    (cnt_q),
        .trk_en (en_trk),
        .tc     (tc)
    );

    generate
        if (ASYNC_CLEAR) begin : g_async_clr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_d;
            end

            // R3: clear holds the register empty while asserted
            a_r3_async_clear: assert property (@(posedge clk)
                !clr_n |-> (count == '0));
        end else begin : g_sync_clr
            always_ff @(posedge clk) begin
                cnt_q <= cnt_d;
            end

            // R4: clear sampled at an edge empties the register after it
            a_r4_sync_clear: assert property (@(posedge clk)
                !clr_n |=> (count == '0));
        end
    endgenerate

    assign count = cnt_q;

    // R1: increment by one when both enables are high and no load
    a_r1_count_step: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_par && en_trk) |=> (count == $past(count) + ONE));

    // R2: load takes din whatever the enables
    a_r2_load_din: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> (count == $past(din)));

    // R5: a low enable freezes the count
    a_r5_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_par && en_trk)) |=> $stable(count));

    // R6: terminal count is gated by the trickle enable only
    a_r6_tc_gate: assert property (@(posedge clk) disable iff (!clr_n)
        !en_trk |-> !tc);

    a_r6_tc_full: assert property (@(posedge clk) disable iff (!clr_n)
        (en_trk && count == ALL_ONES) |-> tc);

    // R7: counting out of all ones lands on zero
    a_r7_wrap: assert property (@(posedge clk) disable iff (!clr_n)
        (count == ALL_ONES && load_n && en_par && en_trk) |=> (count == '0));

endmodule

// File: tb/psync_counter_bench.sv
module psync_counter_bench;

    logic       clk = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_ext_s = 1'b0;
    logic       mod7 = 1'b0;
    logic       load_n = 1'b1;
    logic       en_par = 1'b0;
    logic       en_trk = 1'b0;
    logic [3:0] din = 4'd0;

    logic [3:0] cnt_a, cnt_s;
    logic       tc_a, tc_s;
    logic       clr_s;

    int n_checks = 0;
    int n_fails  = 0;
    logic [3:0] m_a = 4'd0;
    logic [3:0] m_s = 4'd0;

    always #4 clk = ~clk;

    assign clr_s = clr_ext_s & ~(mod7 & (cnt_s == 4'd6));

    psync_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b1)) u_psync_counter (
        .clk(clk), .clr_n(clr_a), .load_n(load_n), .en_par(en_par),
        .en_trk(en_trk), .din(din), .count(cnt_a), .tc(tc_a)
    );

    psync_counter #(.WIDTH(4), .ASYNC_CLEAR(1'b0)) u_psync_counter_sc (
        .clk(clk), .clr_n(clr_s), .load_n(load_n), .en_par(en_par),
        .en_trk(en_trk), .din(din), .count(cnt_s), .tc(tc_s)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] model_next(input logic [3:0] m, input logic clr);
        if (!clr) return 4'd0;
        if (!load_n) return din;
        if (en_par && en_trk) return m + 4'd1;
        return m;
    endfunction

    task automatic step();
        logic eff_s;
        @(posedge clk);
        eff_s = clr_ext_s & ~(mod7 & (m_s == 4'd6));
        m_a = model_next(m_a, clr_a);
        m_s = model_next(m_s, eff_s);
        #2;
    endtask

    function automatic int tc_of(input logic [3:0] m);
        return (m == 4'hF && en_trk) ? 1 : 0;
    endfunction

    task automatic both(input string req);
        chk({req, " async count"}, cnt_a, m_a);
        chk({req, " sync count"}, cnt_s, m_s);
        chk({req, " async tc"}, tc_a, tc_of(m_a));
        chk({req, " sync tc"}, tc_s, tc_of(m_s));
    endtask

    task automatic t_reset();
        load_n = 1'b0; din = 4'd9; en_par = 1'b1; en_trk = 1'b1;
        step();
        both("R9 reset");
        chk("R9 reset zero", cnt_a, 0);
        clr_a = 1'b1; clr_ext_s = 1'b1; load_n = 1'b1;
    endtask

    task automatic t_count();
        for (int i = 0; i < 5; i++) begin
            step();
            both("R1 count");
        end
        chk("R1 reached five", cnt_a, 5);
    endtask

    task automatic t_hold();
        en_par = 1'b0; step(); both("R5 hold par low");
        en_par = 1'b1; en_trk = 1'b0; step(); both("R5 hold trk low");
        en_par = 1'b0; step(); both("R5 hold both low");
    endtask

    task automatic t_load();
        en_par = 1'b0; en_trk = 1'b0; load_n = 1'b0; din = 4'd10;
        step(); both("R2 load enables low");
        en_par = 1'b1; en_trk = 1'b1; din = 4'd3;
        step(); both("R2 load enables high");
        chk("R2 load value", cnt_s, 3);
        load_n = 1'b1;
    endtask

    task automatic t_wrap_tc();
        load_n = 1'b0; din = 4'd14; step(); both("R2 preload 14");
        load_n = 1'b1; step(); both("R1 to 15");
        chk("R6 tc at 15", tc_a, 1);
        en_trk = 1'b0; #1;
        chk("R6 tc drops with trickle", tc_a, 0);
        chk("R6 tc drops with trickle sync", tc_s, 0);
        en_trk = 1'b1; en_par = 1'b0; #1;
        chk("R6 tc ignores par enable", tc_a, 1);
        step(); both("R5 hold at 15");
        en_par = 1'b1; step(); both("R7 wrap");
        chk("R7 wrap zero", cnt_a, 0);
        chk("R7 tc low after wrap", tc_a, 0);
    endtask

    task automatic t_clear();
        load_n = 1'b0; din = 4'd9; step(); both("R2 preload 9");
        clr_a = 1'b0; clr_ext_s = 1'b0; #1;
        m_a = 4'd0;
        chk("R3 async clear no edge", cnt_a, 0);
        chk("R4 sync clear waits", cnt_s, 9);
        step();
        chk("R4 sync clear beats load", cnt_s, 0);
        chk("R3 async stays zero", cnt_a, 0);
        clr_a = 1'b1; clr_ext_s = 1'b1; load_n = 1'b1;
        step(); both("R9 count after clear");
    endtask

    task automatic t_mod7();
        clr_ext_s = 1'b0; step();
        clr_ext_s = 1'b1; mod7 = 1'b1; en_par = 1'b1; en_trk = 1'b1;
        for (int i = 1; i <= 15; i++) begin
            step();
            chk("R8 modulo seven", cnt_s, i % 7);
        end
        mod7 = 1'b0;
    endtask

    initial begin : watchdog
        #100000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2;
        t_reset();
        t_count();
        t_hold();
        t_load();
        t_wrap_tc();
        t_clear();
        t_mod7();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule